// File: doc/BRIEF.md
# Guest-Stage Translation Invalidate Request Unit

This unit sits in the execute stage of a processor that runs a hypervisor. It handles the guest-physical invalidate instruction. For each instruction it receives, it either raises a synchronous exception, does nothing, or issues exactly one invalidation command to the address-translation caches.

The unit first checks privilege. It then chooses the width of the invalidation. The choice depends on which source register *indices* are zero. The register values do not affect it. Two things go onto the command: the low bits of the second source value, which form the virtual-machine identifier (VMID), and the first source value, which forms the guest physical address.

An address with any bit set above the supported guest-physical width is non-canonical. A non-canonical address turns an address-scoped request into a silent no-op. No fault is raised in that case.

The command leaves through a valid/ready handshake. While a command waits, the unit does not accept a new instruction and reports itself busy.

Top module: `gstage_inval_unit`

## Requirements
- R1: The rs1 index is read from instruction bits 19:15. The rs2 index is read from instruction bits 24:20. The port `req_src_fld` carries instruction bits 24:15, so its bit 0 is instruction bit 15.
- R2: Mode code 2 (user) raises exception cause 2 (illegal instruction). The exception is a one-cycle pulse on `exc_valid` in the cycle after acceptance, and no command is issued.
- R3: Mode code 1 (host supervisor) with `req_tvm` = 1 raises cause 2. With `req_tvm` = 0 the instruction executes.
- R4: Mode codes 3 (virtual supervisor) and 4 (virtual user) raise cause 22 (virtual instruction), whatever the value of `req_tvm`.
- R5: Mode code 0 (machine) never raises an exception, whatever the value of `req_tvm`.
- R6: When both indices are zero, the command has scope code 0 (global). Its VMID and address fields are zero.
- R7: When the rs1 index is zero and the rs2 index is nonzero, the scope code is 1 (one VMID). The VMID field equals `req_rs2_vmid` and the address field is zero. Address canonicity is ignored in this case.
- R8: When the rs1 index is nonzero and the rs2 index is zero, and the address is canonical, the scope code is 2 (one address). The address field equals the low GPA_W bits of `req_rs1_val` and the VMID field is zero.
- R9: When both indices are nonzero and the address is canonical, the scope code is 3. The command carries both the VMID and the address.
- R10: When the rs1 index is nonzero and any bit of `req_rs1_val` at or above GPA_W is set, the unit issues no command and raises no exception.
- R11: While `cmd_valid` is high and `cmd_ready` is low, every command field holds steady, `busy` is high and `req_ready` is low. A `req_valid` in that period is ignored. `cmd_valid` falls after the edge where `cmd_ready` is seen high.
- R12: The exception checks run in a fixed priority: user mode first, then host supervisor with the trap bit set, then the virtual modes. Any exception suppresses the command, including when the address is non-canonical.
- R13: Every issued command has `cmd_gstage` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction present this cycle |
| req_ready | output | 1 | Unit can accept an instruction |
| req_src_fld | input | 10 | Instruction bits 24:15 |
| req_mode | input | 3 | Privilege mode code (0 M, 1 HS, 2 U, 3 VS, 4 VU) |
| req_tvm | input | 1 | Trap-virtual-memory status bit |
| req_rs1_val | input | XLEN | First source value (guest physical address) |
| req_rs2_vmid | input | VMID_W | Low VMID_W bits of the second source value |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 5 | Exception cause code |
| busy | output | 1 | A command is waiting for acceptance |
| cmd_valid | output | 1 | Invalidation command valid |
| cmd_ready | input | 1 | Translation caches accept the command |
| cmd_gstage | output | 1 | Guest-stage flag |
| cmd_scope | output | 2 | Scope code |
| cmd_vmid | output | VMID_W | Target VMID |
| cmd_gpa | output | GPA_W | Target guest physical address |

## Verification
A faulty privilege gate shows up in the cycle after acceptance in one of two ways: a pulse with the wrong cause, or a command where a pulse belongs. A wrong scope or canonicity decision shows up in that same cycle, as a wrong scope code, a stray field value, or a command that should have been dropped. A fault in the holding register only shows up under backpressure. It appears as a field that changes, or as a second instruction that slips in, while `cmd_ready` is held low. The bench therefore holds ready low for several cycles and keeps offering new requests during that time.

// File: rtl/gsinv_pkg.sv
package gsinv_pkg;

  typedef enum logic [2:0] {
    PRV_M  = 3'd0,
    PRV_HS = 3'd1,
    PRV_U  = 3'd2,
    PRV_VS = 3'd3,
    PRV_VU = 3'd4
  } prv_e;

  typedef enum logic [1:0] {
    SC_ALL  = 2'd0,
    SC_VMID = 2'd1,
    SC_ADDR = 2'd2,
    SC_BOTH = 2'd3
  } scope_e;

  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = 5'd22;

  typedef struct packed {
    logic               fault;
    logic [CAUSE_W-1:0] cause;
  } fault_t;

  // Ordered privilege gate: user, then trapped HS, then virtual modes.
  function automatic fault_t f_fault(input logic [2:0] mode, input logic tvm);
    fault_t r;
    r.fault = 1'b0;
    r.cause = '0;
    if (mode == PRV_U) begin
      r.fault = 1'b1;
      r.cause = CAUSE_ILLEGAL;
    end else if (mode == PRV_HS && tvm) begin
      r.fault = 1'b1;
      r.cause = CAUSE_ILLEGAL;
    end else if (mode == PRV_VS || mode == PRV_VU) begin
      r.fault = 1'b1;
      r.cause = CAUSE_VIRTUAL;
    end else if (mode != PRV_M && mode != PRV_HS) begin
      r.fault = 1'b1;
      r.cause = CAUSE_ILLEGAL;
    end
    return r;
  endfunction

  // Scope from which source indices are nonzero: bit1 address, bit0 VMID.
  function automatic scope_e f_scope(input logic rs1_nz, input logic rs2_nz);
    return scope_e'({rs1_nz, rs2_nz});
  endfunction

endpackage

// File: rtl/gsinv_priv_gate.sv
module gsinv_priv_gate
  import gsinv_pkg::*;
(
  input  logic [2:0]         mode,
  input  logic               tvm,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  fault_t res;

  always_comb begin
    res   = f_fault(mode, tvm);
    fault = res.fault;
    cause = res.cause;
  end
endmodule

// File: rtl/gsinv_scope_sel.sv
module gsinv_scope_sel
  import gsinv_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned GPA_W  = 41,
  parameter int unsigned VMID_W = 14
) (
  input  logic [4:0]        rs1_idx,
  input  logic [4:0]        rs2_idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [VMID_W-1:0] rs2_vmid,
  output logic [1:0]        scope,
  output logic [VMID_W-1:0] vmid,
  output logic [GPA_W-1:0]  gpa,
  output logic              drop
);
  logic rs1_nz, rs2_nz, canon;

  assign rs1_nz = (rs1_idx != 5'd0);
  assign rs2_nz = (rs2_idx != 5'd0);

  generate
    if (GPA_W >= XLEN) begin : g_full
      assign canon = 1'b1;
    end else begin : g_part
      localparam int unsigned HI_W = XLEN - GPA_W;
      assign canon = (rs1_val[XLEN-1:GPA_W] == {HI_W{1'b0}});
    end
  endgenerate

  always_comb begin
    scope = f_scope(rs1_nz, rs2_nz);
    vmid  = rs2_nz ? rs2_vmid : '0;
    gpa   = rs1_nz ? rs1_val[GPA_W-1:0] : '0;
    drop  = rs1_nz && !canon;
  end
endmodule

// File: rtl/gsinv_cmd_hold.sv
module gsinv_cmd_hold #(
  parameter int unsigned GPA_W  = 41,
  parameter int unsigned VMID_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        ld_scope,
  input  logic [VMID_W-1:0] ld_vmid,
  input  logic [GPA_W-1:0]  ld_gpa,
  input  logic              ready,
  output logic              valid,
  output logic [1:0]        scope,
  output logic [VMID_W-1:0] vmid,
  output logic [GPA_W-1:0]  gpa,
  output logic              done
);
  assign done = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      scope <= '0;
      vmid  <= '0;
      gpa   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      scope <= ld_scope;
      vmid  <= ld_vmid;
      gpa   <= ld_gpa;
    end else if (done) begin
      valid <= 1'b0;
      scope <= '0;
      vmid  <= '0;
      gpa   <= '0;
    end
  end
endmodule

// File: rtl/gstage_inval_unit.sv
module gstage_inval_unit
  import gsinv_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned GPA_W  = 41,
  parameter int unsigned VMID_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [9:0]        req_src_fld,
  input  logic [2:0]        req_mode,
  input  logic              req_tvm,
  input  logic [XLEN-1:0]   req_rs1_val,
  input  logic [VMID_W-1:0] req_rs2_vmid,
  output logic              exc_valid,
  output logic [4:0]        exc_cause,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_gstage,
  output logic [1:0]        cmd_scope,
  output logic [VMID_W-1:0] cmd_vmid,
  output logic [GPA_W-1:0]  cmd_gpa
);
  // Field positions relative to instruction bit 15.
  localparam int unsigned RS1_LO = 0;
  localparam int unsigned RS2_LO = 5;

  logic [4:0]         rs1_idx, rs2_idx;
  logic               fault;
  logic [CAUSE_W-1:0] cause;
  logic [1:0]         sel_scope;
  logic [VMID_W-1:0]  sel_vmid;
  logic [GPA_W-1:0]   sel_gpa;
  logic               sel_drop;
  logic               cmd_done;

  // Named events for the checker.
  logic ev_accept, ev_fault, ev_drop, ev_issue;

  assign rs1_idx = req_src_fld[RS1_LO +: 5];
  assign rs2_idx = req_src_fld[RS2_LO +: 5];

  gsinv_priv_gate u_gate (
    .mode  (req_mode),
    .tvm   (req_tvm),
    .fault (fault),
    .cause (cause)
  );

  gsinv_scope_sel #(.XLEN(XLEN), .GPA_W(GPA_W), .VMID_W(VMID_W)) u_sel (
    .rs1_idx  (rs1_idx),
    .rs2_idx  (rs2_idx),
    .rs1_val  (req_rs1_val),
    .rs2_vmid (req_rs2_vmid),
    .scope    (sel_scope),
    .vmid     (sel_vmid),
    .gpa      (sel_gpa),
    .drop     (sel_drop)
  );

  assign req_ready = !cmd_valid;
  assign ev_accept = req_valid && req_ready;
  assign ev_fault  = ev_accept && fault;
  assign ev_drop   = ev_accept && !fault && sel_drop;
  assign ev_issue  = ev_accept && !fault && !sel_drop;

  gsinv_cmd_hold #(.GPA_W(GPA_W), .VMID_W(VMID_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_issue),
    .ld_scope (sel_scope),
    .ld_vmid  (sel_vmid),
    .ld_gpa   (sel_gpa),
    .ready    (cmd_ready),
    .valid    (cmd_valid),
    .scope    (cmd_scope),
    .vmid     (cmd_vmid),
    .gpa      (cmd_gpa),
    .done     (cmd_done)
  );

  assign busy       = cmd_valid;
  assign cmd_gstage = cmd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
    end else begin
      exc_valid <= ev_fault;
      exc_cause <= ev_fault ? cause : '0;
    end
  end
endmodule

// File: rtl/gsinv_chk.sv
module gsinv_chk #(
  parameter int unsigned GPA_W  = 41,
  parameter int unsigned VMID_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              exc_valid,
  input logic [4:0]        exc_cause,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_gstage,
  input logic [1:0]        cmd_scope,
  input logic [VMID_W-1:0] cmd_vmid,
  input logic [GPA_W-1:0]  cmd_gpa,
  input logic              ev_drop,
  input logic              ev_fault
);
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_scope) && $stable(cmd_vmid) && $stable(cmd_gpa));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R13
  gstage_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_gstage);

  // R2
  exc_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !cmd_valid);

  // R4
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == 5'd2 || exc_cause == 5'd22));

  // R10
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !cmd_valid && !exc_valid);

  // R12
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> exc_valid && !cmd_valid);

  // R6
  global_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_scope == 2'd0 |-> cmd_vmid == '0 && cmd_gpa == '0);

  // R8
  addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_scope == 2'd2 |-> cmd_vmid == '0);

  // R7
  vmid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_scope == 2'd1 |-> cmd_gpa == '0);
endmodule

bind gstage_inval_unit gsinv_chk #(.GPA_W(GPA_W), .VMID_W(VMID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .busy       (busy),
  .exc_valid  (exc_valid),
  .exc_cause  (exc_cause),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_gstage (cmd_gstage),
  .cmd_scope  (cmd_scope),
  .cmd_vmid   (cmd_vmid),
  .cmd_gpa    (cmd_gpa),
  .ev_drop    (ev_drop),
  .ev_fault   (ev_fault)
);

// File: tb/test_gstage_inval_unit.sv
module test_gstage_inval_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN   = 64;
  localparam int GPA_W  = 41;
  localparam int VMID_W = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [9:0]        req_src_fld = '0;
  logic [2:0]        req_mode = '0;
  logic              req_tvm = 1'b0;
  logic [XLEN-1:0]   req_rs1_val = '0;
  logic [VMID_W-1:0] req_rs2_vmid = '0;
  logic              exc_valid;
  logic [4:0]        exc_cause;
  logic              busy;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic              cmd_gstage;
  logic [1:0]        cmd_scope;
  logic [VMID_W-1:0] cmd_vmid;
  logic [GPA_W-1:0]  cmd_gpa;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gstage_inval_unit #(.XLEN(XLEN), .GPA_W(GPA_W), .VMID_W(VMID_W)) i_gstage_inval_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src_fld(req_src_fld), .req_mode(req_mode), .req_tvm(req_tvm),
    .req_rs1_val(req_rs1_val), .req_rs2_vmid(req_rs2_vmid),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_gstage(cmd_gstage),
    .cmd_scope(cmd_scope), .cmd_vmid(cmd_vmid), .cmd_gpa(cmd_gpa)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cause expected from the mode table, in priority order.
  function automatic int exp_cause(input int mode, input bit tvm);
    if (mode == 2) return 2;
    if (mode == 1 && tvm) return 2;
    if (mode == 3 || mode == 4) return 22;
    return 0;
  endfunction

  task automatic run_vec(input int mode, input bit tvm, input logic [4:0] i1, input logic [4:0] i2,
                         input logic [63:0] v1, input logic [VMID_W-1:0] v2, input int hold, input bit poke);
    int ec;
    bit noncanon, drop;
    logic [1:0] sc;
    logic [VMID_W-1:0] ev;
    logic [GPA_W-1:0] eg;
    ec = exp_cause(mode, tvm);
    noncanon = (v1 >> GPA_W) != 0;
    drop = (i1 != 0) && noncanon;
    sc = {i1 != 0, i2 != 0};
    ev = (i2 != 0) ? v2 : '0;
    eg = (i1 != 0) ? v1[GPA_W-1:0] : '0;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_src_fld = {i2, i1};   // R1: bits 24:20 then 19:15
    req_mode = 3'(mode);
    req_tvm = tvm;
    req_rs1_val = v1;
    req_rs2_vmid = v2;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ec != 0) begin
      // R2 R3 R4 R12
      check(exc_valid && exc_cause == 5'(ec), "R12 exception cause", 64'(exc_cause), 64'(ec));
      check(!cmd_valid, "R2 no command on fault", 64'(cmd_valid), 64'd0);
      @(negedge clk);
      check(!exc_valid, "R2 single pulse", 64'(exc_valid), 64'd0);
    end else if (drop) begin
      check(!cmd_valid && !exc_valid, "R10 silent drop", 64'({cmd_valid, exc_valid}), 64'd0);
    end else begin
      check(!exc_valid, "R5 no exception", 64'(exc_valid), 64'd0);
      check(cmd_valid && cmd_gstage, "R13 command gstage", 64'({cmd_valid, cmd_gstage}), 64'd3);
      check(cmd_scope == sc, sc == 0 ? "R6 scope" : sc == 1 ? "R7 scope" : sc == 2 ? "R8 scope" : "R9 scope",
            64'(cmd_scope), 64'(sc));
      check(cmd_vmid == ev, "R7 vmid field", 64'(cmd_vmid), 64'(ev));
      check(cmd_gpa == eg, "R8 gpa field", 64'(cmd_gpa), 64'(eg));
      for (int k = 0; k < hold; k++) begin
        if (poke) begin
          req_valid = 1'b1;
          req_src_fld = 10'h3FF;
          req_mode = 3'd0;
          req_rs1_val = 64'h1;
        end
        @(negedge clk);
        check(cmd_valid && busy && !req_ready, "R11 busy hold", 64'({cmd_valid, busy, req_ready}), 64'd6);
        check(cmd_scope == sc && cmd_vmid == ev && cmd_gpa == eg, "R11 fields stable",
              64'(cmd_gpa), 64'(eg));
      end
      req_valid = 1'b0;
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      check(!cmd_valid && req_ready, "R11 release", 64'({cmd_valid, req_ready}), 64'd1);
      @(negedge clk);
      check(!cmd_valid && !exc_valid, "R11 poke ignored", 64'({cmd_valid, exc_valid}), 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!exc_valid && !cmd_valid && req_ready && !busy, "R11 reset state",
          64'({exc_valid, cmd_valid, req_ready, busy}), 64'd2);
    // Sweep: mode x trap bit x index pattern x canonicity.
    for (int m = 0; m < 5; m++)
      for (int t = 0; t < 2; t++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            int n = m * 16 + t * 8 + p * 2 + c;
            logic [4:0] i1 = p[1] ? 5'(1 + (n * 7) % 31) : 5'd0;
            logic [4:0] i2 = p[0] ? 5'(1 + (n * 11) % 31) : 5'd0;
            logic [63:0] v1 = 64'h0000_00AB_CDEF_1234 + 64'(n * 64'h1_0001);
            logic [VMID_W-1:0] v2 = VMID_W'(14'h2A5 + n * 97);
            if (c == 1) v1 = v1 | (64'd1 << (GPA_W + (n % (XLEN - GPA_W))));
            run_vec(m, t[0], i1, i2, v1, v2, n % 3, 1'b0);
          end
    // R11 backpressure with new requests offered while pending
    run_vec(0, 1'b1, 5'd9, 5'd31, 64'h1FF_FFFF_FFFF, 14'h3FFF, 5, 1'b1);
    run_vec(1, 1'b0, 5'd0, 5'd4, 64'hFFFF_0000_0000_0000, 14'h1234, 4, 1'b1);
    // R12 user mode beats non-canonical address and trap bit
    run_vec(2, 1'b1, 5'd3, 5'd0, 64'h8000_0000_0000_0000, 14'h0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule